// File: doc/BRIEF.md
# LED Driver Chain Frame Sequencer

This block is the host side of a cascaded chain of constant-current LED drivers that have serial inputs and one-shot PWM outputs. A frame-start strobe begins the frame. The block then serializes luminance words from a ready/valid input onto the chain's serial data line under the shift command. It also runs a fixed number of brightness slots. In each slot it stops the grayscale clock, sends a disable, sends either an emit or a second disable, and then lets the clock run again. The frame ends with a single capture command, which latches the shifted words for the next frame's slots.

The PWM in each driver fires once per emit. Overall panel brightness is therefore the number of slots in a frame that carry an emit. That number is taken from the `level` input when the frame starts. Slot commands take priority over shifting: shifting pauses for three cycles at each slot and then continues. Between slots the grayscale clock runs for a full PWM period plus the driver's start latency. Because the clock is held low during every disable and emit, the two clocks never need a fixed phase relation.

Top module: `fseq_frame_sequencer`

## Requirements
- R1: After reset, `drv_cmd` is 3'b000 (no-op), `gs_clk_en` is 1, `drv_sdata` is 0, and `busy` and `in_ready` are 0.
- R2: A `frame_start` sampled while `busy` is 0 makes `busy` 1 from the next cycle. A `frame_start` sampled while `busy` is 1 has no effect.
- R3: With P = PWM_LEN + GS_LAT + 3, slot k (k = 0..SLOTS-1) covers output cycles 1+kP to 3+kP, counted from the edge that accepted the start. In those three cycles `drv_cmd` is 3'b000, then 3'b110 (disable), then the slot's decision, and `gs_clk_en` is 0 in all three.
- R4: Every emit command (3'b100) is immediately preceded by a disable (3'b110).
- R5: The decision in slot k is emit when k is less than the sampled level and disable otherwise. Level 0 gives only disables. A level above SLOTS emits in every slot.
- R6: Outside the slot windows `gs_clk_en` is 1. Between slots it stays 1 for PWM_LEN + GS_LAT consecutive cycles.
- R7: Each accepted word is sent MSB first, one bit per shift command (3'b010). Each bit appears on `drv_sdata` in the cycle after its shift command. `drv_sdata` is 0 at all other times.
- R8: No shift command is issued inside a slot window. Shifting continues in the first cycle after the window if bits are pending.
- R9: `in_ready` is 1 only while the frame still needs words and no bits of the previous word are left to send. A word is taken on a cycle where `in_valid` and `in_ready` are both 1.
- R10: Capture (3'b011) is issued exactly once per frame. It comes no earlier than output cycle SLOTS*P after the start, only after all WORDS words have been sent, and never directly after a shift command. `busy` falls in the same cycle that capture appears.
- R11: A change on `level` during a frame does not change that frame's slot decisions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the serial command clock of the chain |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Starts a frame when idle |
| level | input | $clog2(SLOTS+1) | Number of emit slots for the frame, sampled at start |
| in_valid | input | 1 | Luminance word valid |
| in_word | input | WORD_W | Luminance word |
| in_ready | output | 1 | Word can be taken this cycle |
| busy | output | 1 | Frame in progress, capture not yet issued |
| drv_cmd | output | 3 | Command bus to the driver chain |
| drv_sdata | output | 1 | Serial luminance data to the chain |
| gs_clk_en | output | 1 | Enable for the grayscale clock gate |

## Verification
`busy` and `in_ready` change one cycle after the edge that samples `frame_start`. A word accepted at one edge produces its first shift command one edge later, and each bit reaches `drv_sdata` one further edge after its command. The slot commands and the clock enable appear 1+kP to 3+kP edges after the accepting edge. The bench model steps through the same edges, computing each output from the state it held before that edge. It compares all five outputs half a cycle after every edge, so each result is checked in exactly the cycle it is due. End-of-frame checks also count emits, disables and captures, and rebuild the serial words from `drv_sdata`.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  typedef enum logic [2:0] {
    CMD_NOP     = 3'b000,
    CMD_SHIFT   = 3'b010,
    CMD_CAPTURE = 3'b011,
    CMD_EMIT    = 3'b100,
    CMD_STOP    = 3'b110
  } drv_cmd_e;

  typedef enum logic [1:0] {
    SL_WAIT = 2'd0,
    SL_GATE = 2'd1,
    SL_DIS  = 2'd2,
    SL_FIRE = 2'd3
  } slot_step_e;
endpackage

// File: rtl/fseq_slot_engine.sv
module fseq_slot_engine
  import fseq_pkg::*;
#(
  parameter int SLOTS   = 160,
  parameter int PWM_LEN = 1024,
  parameter int GS_LAT  = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic [$clog2(SLOTS+1)-1:0]   level,
  output logic                         owns_bus,
  output logic [2:0]                   slot_cmd,
  output logic                         gs_run,
  output logic                         done
);
  localparam int PERIOD = PWM_LEN + GS_LAT + 3;
  localparam int TMR_W  = $clog2(PERIOD);
  localparam int IDX_W  = $clog2(SLOTS + 1);

  slot_step_e       step;
  logic [TMR_W-1:0] tmr;
  logic [IDX_W-1:0] sidx;
  logic [IDX_W-1:0] lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      step <= SL_WAIT;
      tmr  <= '0;
      sidx <= IDX_W'(SLOTS);
      lvl  <= '0;
    end else if (start) begin
      step <= SL_GATE;
      tmr  <= '0;
      sidx <= '0;
      lvl  <= level;
    end else begin
      case (step)
        SL_GATE: step <= SL_DIS;
        SL_DIS:  step <= SL_FIRE;
        SL_FIRE: begin
          step <= SL_WAIT;
          tmr  <= TMR_W'(PERIOD - 4);
          sidx <= sidx + 1'b1;
        end
        default: begin
          if (tmr != '0)
            tmr <= tmr - 1'b1;
          else if (sidx != IDX_W'(SLOTS))
            step <= SL_GATE;
        end
      endcase
    end
  end

  always_comb begin
    case (step)
      SL_DIS:  slot_cmd = CMD_STOP;
      SL_FIRE: slot_cmd = (sidx < lvl) ? CMD_EMIT : CMD_STOP;
      default: slot_cmd = CMD_NOP;
    endcase
  end

  assign owns_bus = (step != SL_WAIT);
  assign gs_run   = (step == SL_WAIT);
  assign done     = (step == SL_WAIT) && (tmr == '0) && (sidx == IDX_W'(SLOTS));
endmodule

// File: rtl/fseq_serializer.sv
module fseq_serializer #(
  parameter int WORD_W = 10,
  parameter int WORDS  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic              take,
  output logic              in_ready,
  output logic              has_bit,
  output logic              head,
  output logic              drained
);
  localparam int BIT_W  = $clog2(WORD_W + 1);
  localparam int WCNT_W = $clog2(WORDS + 1);

  logic [WORD_W-1:0] sreg;
  logic [BIT_W-1:0]  bits_left;
  logic [WCNT_W-1:0] words_left;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg       <= '0;
      bits_left  <= '0;
      words_left <= '0;
    end else if (start) begin
      words_left <= WCNT_W'(WORDS);
    end else if (in_valid && in_ready) begin
      sreg       <= in_word;
      bits_left  <= BIT_W'(WORD_W);
      words_left <= words_left - 1'b1;
    end else if (take) begin
      sreg      <= {sreg[WORD_W-2:0], 1'b0};
      bits_left <= bits_left - 1'b1;
    end
  end

  assign in_ready = (bits_left == '0) && (words_left != '0);
  assign has_bit  = (bits_left != '0);
  assign head     = sreg[WORD_W-1];
  assign drained  = (bits_left == '0) && (words_left == '0);
endmodule

// File: rtl/fseq_frame_sequencer.sv
module fseq_frame_sequencer
  import fseq_pkg::*;
#(
  parameter int WORD_W  = 10,
  parameter int WORDS   = 32,
  parameter int SLOTS   = 160,
  parameter int PWM_LEN = 1024,
  parameter int GS_LAT  = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       frame_start,
  input  logic [$clog2(SLOTS+1)-1:0] level,
  input  logic                       in_valid,
  input  logic [WORD_W-1:0]          in_word,
  output logic                       in_ready,
  output logic                       busy,
  output logic [2:0]                 drv_cmd,
  output logic                       drv_sdata,
  output logic                       gs_clk_en
);
  logic       act;
  logic       start_acc, cap_go, shift_go;
  logic       eng_owns, eng_gs_run, eng_done;
  logic [2:0] eng_cmd;
  logic       ser_has_bit, ser_head, ser_drained;
  logic [2:0] cmd_n, cmd_q;
  logic       bit_q, sdata_q, gs_q, gs_n;

  assign start_acc = frame_start && !act;

  fseq_slot_engine #(
    .SLOTS(SLOTS), .PWM_LEN(PWM_LEN), .GS_LAT(GS_LAT)
  ) eng_i (
    .clk(clk), .rst(rst), .start(start_acc), .level(level),
    .owns_bus(eng_owns), .slot_cmd(eng_cmd), .gs_run(eng_gs_run), .done(eng_done)
  );

  fseq_serializer #(
    .WORD_W(WORD_W), .WORDS(WORDS)
  ) ser_i (
    .clk(clk), .rst(rst), .start(start_acc), .in_valid(in_valid), .in_word(in_word),
    .take(shift_go), .in_ready(in_ready), .has_bit(ser_has_bit), .head(ser_head),
    .drained(ser_drained)
  );

  // Slot commands win the bus; capture waits for slots, data and a gap after shifting.
  assign cap_go   = act && !eng_owns && eng_done && ser_drained && (cmd_q != CMD_SHIFT);
  assign shift_go = act && !eng_owns && !cap_go && ser_has_bit;

  always_comb begin
    if (act && eng_owns) cmd_n = eng_cmd;
    else if (cap_go)     cmd_n = CMD_CAPTURE;
    else if (shift_go)   cmd_n = CMD_SHIFT;
    else                 cmd_n = CMD_NOP;
    gs_n = act ? eng_gs_run : 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act     <= 1'b0;
      cmd_q   <= CMD_NOP;
      bit_q   <= 1'b0;
      sdata_q <= 1'b0;
      gs_q    <= 1'b1;
    end else begin
      if (start_acc)   act <= 1'b1;
      else if (cap_go) act <= 1'b0;
      cmd_q   <= cmd_n;
      bit_q   <= shift_go ? ser_head : 1'b0;
      sdata_q <= (cmd_q == CMD_SHIFT) ? bit_q : 1'b0;
      gs_q    <= gs_n;
    end
  end

  assign busy      = act;
  assign drv_cmd   = cmd_q;
  assign drv_sdata = sdata_q;
  assign gs_clk_en = gs_q;
endmodule

// File: rtl/fseq_checker.sv
module fseq_checker (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       in_ready,
  input logic [2:0] drv_cmd,
  input logic       drv_sdata,
  input logic       gs_clk_en
);
  assert_stop_before_emit_R4: assert property (@(posedge clk) disable iff (rst)
    (drv_cmd == 3'b100) |-> ($past(drv_cmd) == 3'b110));

  assert_gated_slot_cmd_R3: assert property (@(posedge clk) disable iff (rst)
    (drv_cmd == 3'b100 || drv_cmd == 3'b110) |-> !gs_clk_en);

  assert_no_shift_in_window_R8: assert property (@(posedge clk) disable iff (rst)
    (drv_cmd == 3'b010) |-> gs_clk_en);

  assert_data_after_shift_R7: assert property (@(posedge clk) disable iff (rst)
    drv_sdata |-> ($past(drv_cmd) == 3'b010));

  assert_busy_ends_on_capture_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (drv_cmd == 3'b011));

  assert_ready_only_in_frame_R9: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> busy);
endmodule

bind fseq_frame_sequencer fseq_checker chk_i (
  .clk(clk), .rst(rst), .busy(busy), .in_ready(in_ready),
  .drv_cmd(drv_cmd), .drv_sdata(drv_sdata), .gs_clk_en(gs_clk_en)
);

// File: tb/fseq_frame_sequencer_tb_top.sv
`timescale 1ns/1ps
module fseq_frame_sequencer_tb_top;
  localparam int WORD_W = 10, WORDS = 4, SLOTS = 4, PWM_LEN = 32, GS_LAT = 2;
  localparam int P = PWM_LEN + GS_LAT + 3;
  localparam int LW = $clog2(SLOTS + 1);
  localparam int C_NOP = 0, C_SHIFT = 2, C_CAP = 3, C_EMIT = 4, C_STOP = 6;

  logic clk = 1'b0, rst = 1'b1, frame_start = 1'b0, in_valid = 1'b0;
  logic [LW-1:0] level = '0;
  logic [WORD_W-1:0] in_word = '0;
  logic in_ready, busy, drv_sdata, gs_clk_en;
  logic [2:0] drv_cmd;

  always #2.5 clk = ~clk;

  fseq_frame_sequencer #(.WORD_W(WORD_W), .WORDS(WORDS), .SLOTS(SLOTS),
    .PWM_LEN(PWM_LEN), .GS_LAT(GS_LAT)) dut_i (
    .clk(clk), .rst(rst), .frame_start(frame_start), .level(level),
    .in_valid(in_valid), .in_word(in_word), .in_ready(in_ready), .busy(busy),
    .drv_cmd(drv_cmd), .drv_sdata(drv_sdata), .gs_clk_en(gs_clk_en));

  int vecs = 0, fails = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  endtask

  // Behavioural reference: timeline of the frame plus a bit queue.
  bit m_act, hs;
  int rel, lvl, wl;
  bit q[$];
  int e_cmd = C_NOP, e_bit, e_sd, e_gs = 1, e_busy, e_rdy;
  string e_tag = "R1";

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_act = 0; rel = 0; lvl = 0; wl = 0; q.delete(); hs = 0;
      e_cmd = C_NOP; e_bit = 0; e_sd = 0; e_gs = 1; e_busy = 0; e_rdy = 0; e_tag = "R1";
    end else begin
      int n_cmd, n_bit, n_gs; bit cap, act0; string n_tag;
      n_cmd = C_NOP; n_bit = 0; n_gs = 1; cap = 0; act0 = m_act; n_tag = "R8";
      if (m_act) begin
        if (rel < SLOTS * P && (rel % P) < 3) begin
          n_gs = 0; n_tag = "R3";
          if (rel % P == 1) n_cmd = C_STOP;
          else if (rel % P == 2) begin
            n_cmd = (rel / P < lvl) ? C_EMIT : C_STOP; n_tag = "R5";
          end
        end else if (rel >= SLOTS * P - 1 && q.size() == 0 && wl == 0 && e_cmd != C_SHIFT) begin
          n_cmd = C_CAP; cap = 1; n_tag = "R10";
        end else if (q.size() != 0) begin
          n_cmd = C_SHIFT; n_bit = q.pop_front(); n_tag = "R7";
        end
      end
      e_sd = (e_cmd == C_SHIFT) ? e_bit : 0;
      e_cmd = n_cmd; e_bit = n_bit; e_gs = n_gs; e_tag = n_tag;
      hs = in_valid && (e_rdy != 0);
      if (hs) begin
        for (int b = WORD_W - 1; b >= 0; b--) q.push_back(in_word[b]);
        wl--;
      end
      if (m_act) rel++;
      if (cap) m_act = 0;
      else if (!act0 && frame_start) begin
        m_act = 1; rel = 0; lvl = int'(level); wl = WORDS;
      end
      e_busy = m_act;
      e_rdy = (q.size() == 0 && wl > 0) ? 1 : 0;
    end
  end

  // Per-cycle comparison, frame statistics and word feeder.
  int emits, stops, caps, prev_cmd = C_NOP, feed_idx = 0, feed_gap = 1;
  int feed_q[$];
  bit rx[$];

  always @(negedge clk) begin
    if (cyc > 0) begin
      chk(int'(drv_cmd) == e_cmd, e_tag, int'(drv_cmd), e_cmd);
      chk(int'(gs_clk_en) == e_gs, "R6", int'(gs_clk_en), e_gs);
      chk(int'(drv_sdata) == e_sd, "R7", int'(drv_sdata), e_sd);
      chk(int'(busy) == e_busy, "R2", int'(busy), e_busy);
      chk(int'(in_ready) == e_rdy, "R9", int'(in_ready), e_rdy);
      if (int'(drv_cmd) == C_EMIT) chk(prev_cmd == C_STOP, "R4", prev_cmd, C_STOP);
    end
    if (int'(drv_cmd) == C_EMIT) emits++;
    if (int'(drv_cmd) == C_STOP) stops++;
    if (int'(drv_cmd) == C_CAP) caps++;
    if (prev_cmd == C_SHIFT) rx.push_back(drv_sdata);
    prev_cmd = int'(drv_cmd);
    if (hs) begin feed_idx++; hs = 0; end
    in_valid = (feed_idx < feed_q.size()) && (cyc % feed_gap == 0);
    in_word  = (feed_idx < feed_q.size()) ? WORD_W'(feed_q[feed_idx]) : '0;
  end

  always @(posedge clk) if (cyc > 150000) begin
    fails++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cyc, 150000);
    finish_run();
  end

  task automatic run_frame(input int lv, input int gap, input bit disturb, input int seed);
    int n, exp_e;
    string tg;
    feed_q.delete();
    for (int w = 0; w < WORDS; w++) feed_q.push_back((seed * 37 + w * 211 + 5) % (1 << WORD_W));
    feed_idx = 0; feed_gap = gap; emits = 0; stops = 0; caps = 0; rx.delete();
    @(negedge clk); #1; level = LW'(lv); frame_start = 1'b1;
    @(negedge clk); #1; frame_start = 1'b0;
    n = 0;
    while (busy && n < 5000) begin
      @(negedge clk); #1; n++;
      if (disturb && n == 40) begin level = '0; frame_start = 1'b1; end
      else frame_start = 1'b0;
    end
    frame_start = 1'b0;
    exp_e = (lv < SLOTS) ? lv : SLOTS;
    tg = disturb ? "R11 emit count" : "R5 emit count";
    chk(emits == exp_e, tg, emits, exp_e);
    chk(stops == 2 * SLOTS - exp_e, "R5 disable count", stops, 2 * SLOTS - exp_e);
    chk(caps == 1, "R10 capture count", caps, 1);
    chk(rx.size() == WORD_W * WORDS, "R7 bit count", rx.size(), WORD_W * WORDS);
    for (int w = 0; w < WORDS; w++) begin
      int v = 0;
      for (int b = 0; b < WORD_W; b++)
        if (w * WORD_W + b < rx.size()) v = (v << 1) | int'(rx[w * WORD_W + b]);
      chk(v == feed_q[w], "R7 word", v, feed_q[w]);
    end
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(drv_cmd == 3'b000, "R1 cmd", int'(drv_cmd), 0);
    chk(gs_clk_en == 1'b1, "R1 gs", int'(gs_clk_en), 1);
    chk(drv_sdata == 1'b0, "R1 sdata", int'(drv_sdata), 0);
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(in_ready == 1'b0, "R1 ready", int'(in_ready), 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    run_frame(2, 1, 1'b0, 1);
    run_frame(0, 1, 1'b0, 2);
    run_frame(7, 3, 1'b0, 3);
    run_frame(3, 1, 1'b1, 4);
    run_frame(4, 50, 1'b0, 5);
    run_frame(1, 7, 1'b0, 6);
    finish_run();
  end
endmodule